// File: doc/BRIEF.md
# Gate Pulse Generator

This block produces a repeating gate waveform for a frequency-measurement path. A free-running reference counter advances once per clock, and a compare register marks the next gate edge. On every compare hit the gate toggles and the compare register moves forward by one of two increments. Which increment is used depends on the level the gate has just taken. The high phase is a fixed 40 ms of reference counts. The low phase fills the rest of the requested gate period.

Software supplies the reference frequency as an integer count of clocks per second, and the gate time as an integer number of milliseconds. It then pulses `cfg_load`. A setup state machine clamps the gate time. It works out the high increment and the rounded total period with a shared serial divide-by-1000, and posts the result as pending settings. `cfg_pending` shows that pending settings exist. The phase state machine adopts them only at a rising gate edge, so every period is built from one set of settings. The first settings after reset start the waveform. Loads that arrive while the setup machine is busy are ignored. The reference frequency must be at least 100 so that both phases last one count or more.

The setup machine has three states. `SU_IDLE` goes to `SU_HIGH` on a load. `SU_HIGH` goes to `SU_TOTAL` when the high-count divide completes. `SU_TOTAL` returns to `SU_IDLE` when the total-count divide completes and the pending settings are posted. The phase machine also has three states. `PH_IDLE` goes to `PH_HIGH` on start, when settings are pending. `PH_HIGH` goes to `PH_LOW` on a compare hit. `PH_LOW` goes to `PH_HIGH` on a compare hit, and adopts pending settings if there are any.

Top module: `gate_pulse_gen`

## Requirements
- R1: During reset and afterwards, until the first settings have been computed, `gate_out`, `edge_stb` and `cfg_pending` are 0.
- R2: The high phase of every period lasts floor(ref_hz * 40 / 1000) clock cycles.
- R3: A period (high plus low) lasts round(ref_hz * g / 1000) cycles, where g is the clamped gate time in ms. A fractional part of one half or more rounds up. The low phase is the period minus the high phase.
- R4: A gate time below 50 ms is treated as 50 ms, and one above 60000 ms is treated as 60000 ms.
- R5: When the first settings after reset become ready, the gate rises. Its first compare point is the current counter value plus the high increment, so the waveform starts with a full high phase.
- R6: `cfg_pending` rises once new settings are computed. It falls at the rising gate edge that adopts them. The period starting at that edge uses the new settings, and every earlier period keeps the old ones.
- R7: `edge_stb` is 1 in exactly those cycles in which `gate_out` differs from its value in the previous cycle.
- R8: Compare arithmetic wraps modulo 2^CNT_W, so periods keep their exact lengths when the free-running counter rolls over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter advances once per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_hz | input | REF_W | Reference clock frequency in cycles per second |
| gate_ms | input | GATE_W | Requested gate time in milliseconds |
| cfg_load | input | 1 | One-cycle request to compute new settings from ref_hz and gate_ms |
| gate_out | output | 1 | Gate level |
| edge_stb | output | 1 | One-cycle strobe in the first cycle of each new gate level |
| cfg_pending | output | 1 | New settings are computed but not yet adopted |

## Verification
A wrong increment or a corrupted compare register shows up as a wrong high or low run length, and it does so within the period in which the fault occurs. The monitor therefore measures every high and low run at the ports and compares it with the expected values. A fault in the pending hand-off shows up at the adopting rising edge. At that edge either `cfg_pending` stays set, or the new run lengths appear one period too early or too late. A broken clamp or broken rounding changes only the low run of the first adopted period, which is why the bench checks the clamp limits and both sides of the rounding point.

// File: rtl/gate_pulse_pkg.sv
package gate_pulse_pkg;
    localparam int MS_PER_S = 1000;
    localparam int HIGH_MS  = 40;

    typedef enum logic [1:0] {
        SU_IDLE,
        SU_HIGH,
        SU_TOTAL
    } setup_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW
    } phase_state_e;
endpackage

// File: rtl/gpg_divk.sv
module gpg_divk #(
    parameter int DW = 42,
    parameter int K  = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    output logic          done,
    output logic [DW-1:0] quot
);
    localparam int KW = $clog2(K + 1);
    localparam int SW = $clog2(DW + 1);

    logic          busy;
    logic [SW-1:0] steps;
    logic [KW-1:0] rem;
    logic [DW-1:0] shq;
    logic [KW:0]   trial;
    logic [KW:0]   trial_sub;
    logic          fits;

    always_comb begin
        trial     = {rem, shq[DW-1]};
        fits      = (trial >= (KW+1)'(K));
        trial_sub = trial - (KW+1)'(K);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            steps <= '0;
            rem   <= '0;
            shq   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy  <= 1'b1;
                steps <= SW'(DW);
                rem   <= '0;
                shq   <= dividend;
            end else if (busy) begin
                rem   <= fits ? trial_sub[KW-1:0] : trial[KW-1:0];
                shq   <= {shq[DW-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == SW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = shq;
endmodule

// File: rtl/gpg_setup.sv
module gpg_setup
    import gate_pulse_pkg::*;
#(
    parameter int REF_W    = 26,
    parameter int GATE_W   = 16,
    parameter int CNT_W    = 32,
    parameter int GATE_MIN = 50,
    parameter int GATE_MAX = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REF_W-1:0]  ref_hz,
    input  logic [GATE_W-1:0] gate_ms,
    input  logic              take,
    output logic [CNT_W-1:0]  pend_hi,
    output logic [CNT_W-1:0]  pend_lo,
    output logic              pend_vld
);
    localparam int DW = REF_W + GATE_W;

    setup_state_e      state, nxt;
    logic [REF_W-1:0]  ref_q;
    logic [GATE_W-1:0] gate_q;
    logic [GATE_W-1:0] gate_clamped;
    logic [CNT_W-1:0]  hi_q;
    logic              div_start;
    logic [DW-1:0]     div_in;
    logic              div_done;
    logic [DW-1:0]     div_quot;

    always_comb begin
        if (gate_ms < GATE_W'(GATE_MIN))
            gate_clamped = GATE_W'(GATE_MIN);
        else if (gate_ms > GATE_W'(GATE_MAX))
            gate_clamped = GATE_W'(GATE_MAX);
        else
            gate_clamped = gate_ms;
    end

    always_comb begin
        nxt       = state;
        div_start = 1'b0;
        div_in    = '0;
        unique case (state)
            SU_IDLE: begin
                if (load) begin
                    div_start = 1'b1;
                    div_in    = DW'(ref_hz) * DW'(HIGH_MS);
                    nxt       = SU_HIGH;
                end
            end
            SU_HIGH: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_in    = DW'(ref_q) * DW'(gate_q) + DW'(MS_PER_S / 2);
                    nxt       = SU_TOTAL;
                end
            end
            SU_TOTAL: begin
                if (div_done) nxt = SU_IDLE;
            end
            default: nxt = SU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SU_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= '0;
            gate_q   <= GATE_W'(GATE_MIN);
            hi_q     <= '0;
            pend_hi  <= '0;
            pend_lo  <= '0;
            pend_vld <= 1'b0;
        end else begin
            if (state == SU_IDLE && load) begin
                ref_q  <= ref_hz;
                gate_q <= gate_clamped;
            end
            if (state == SU_HIGH && div_done)
                hi_q <= CNT_W'(div_quot);
            if (state == SU_TOTAL && div_done) begin
                pend_hi  <= hi_q;
                pend_lo  <= CNT_W'(div_quot) - hi_q;
                pend_vld <= 1'b1;
            end else if (take) begin
                pend_vld <= 1'b0;
            end
        end
    end

    gpg_divk #(.DW(DW), .K(MS_PER_S)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_in),
        .done     (div_done),
        .quot     (div_quot)
    );
endmodule

// File: rtl/gpg_phase.sv
module gpg_phase
    import gate_pulse_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pend_hi,
    input  logic [CNT_W-1:0] pend_lo,
    input  logic             pend_vld,
    output logic             take,
    output logic             gate,
    output logic             edge_stb,
    output logic [CNT_W-1:0] hi_act,
    output logic [CNT_W-1:0] lo_act
);
    phase_state_e     state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;
    logic             match;

    assign match = (cnt == cmp);

    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            PH_IDLE: begin
                if (pend_vld) begin
                    nxt  = PH_HIGH;
                    take = 1'b1;
                end
            end
            PH_HIGH: begin
                if (match) nxt = PH_LOW;
            end
            PH_LOW: begin
                if (match) begin
                    nxt  = PH_HIGH;
                    take = pend_vld;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cmp      <= '0;
            hi_act   <= '0;
            lo_act   <= '0;
            edge_stb <= 1'b0;
        end else begin
            cnt      <= cnt + 1'b1;
            edge_stb <= (nxt != state);
            if (take) begin
                hi_act <= pend_hi;
                lo_act <= pend_lo;
            end
            unique case (state)
                PH_IDLE: if (take)  cmp <= cnt + pend_hi;
                PH_HIGH: if (match) cmp <= cmp + lo_act;
                PH_LOW:  if (match) cmp <= cmp + (take ? pend_hi : hi_act);
                default: cmp <= cmp;
            endcase
        end
    end

    assign gate = (state == PH_HIGH);
endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen #(
    parameter int REF_W    = 26,
    parameter int GATE_W   = 16,
    parameter int CNT_W    = 32,
    parameter int GATE_MIN = 50,
    parameter int GATE_MAX = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REF_W-1:0]  ref_hz,
    input  logic [GATE_W-1:0] gate_ms,
    input  logic              cfg_load,
    output logic              gate_out,
    output logic              edge_stb,
    output logic              cfg_pending
);
    logic [CNT_W-1:0] pend_hi;
    logic [CNT_W-1:0] pend_lo;
    logic [CNT_W-1:0] hi_act;
    logic [CNT_W-1:0] lo_act;
    logic             take;

    gpg_setup #(
        .REF_W    (REF_W),
        .GATE_W   (GATE_W),
        .CNT_W    (CNT_W),
        .GATE_MIN (GATE_MIN),
        .GATE_MAX (GATE_MAX)
    ) u_setup (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .ref_hz   (ref_hz),
        .gate_ms  (gate_ms),
        .take     (take),
        .pend_hi  (pend_hi),
        .pend_lo  (pend_lo),
        .pend_vld (cfg_pending)
    );

    gpg_phase #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_hi  (pend_hi),
        .pend_lo  (pend_lo),
        .pend_vld (cfg_pending),
        .take     (take),
        .gate     (gate_out),
        .edge_stb (edge_stb),
        .hi_act   (hi_act),
        .lo_act   (lo_act)
    );
endmodule

// File: rtl/gpg_checker.sv
module gpg_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             stb,
    input logic             pend,
    input logic [CNT_W-1:0] pend_hi,
    input logic [CNT_W-1:0] hi_act,
    input logic [CNT_W-1:0] lo_act
);
    logic             g_d;
    logic             seen_fall;
    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_d       <= 1'b0;
            seen_fall <= 1'b0;
            run_len   <= '0;
        end else begin
            g_d <= gate;
            if (g_d && !gate) seen_fall <= 1'b1;
            if (gate != g_d) run_len <= CNT_W'(1);
            else             run_len <= run_len + 1'b1;
        end
    end

    AST_STB_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        stb == (gate != g_d)); // R7

    AST_HIGH_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (g_d && !gate) |-> (run_len == hi_act)); // R2

    AST_LOW_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_d && gate && seen_fall) |-> (run_len == $past(lo_act))); // R3

    AST_ADOPT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_d && gate && $past(pend)) |-> (hi_act == $past(pend_hi))); // R6

    AST_KEEP_WITHOUT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_d && gate && !$past(pend)) |-> $stable(hi_act)); // R6

    AST_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_fall && !g_d && !gate) |-> !stb); // R1
endmodule

bind gate_pulse_gen gpg_checker #(.CNT_W(CNT_W)) u_gpg_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (gate_out),
    .stb     (edge_stb),
    .pend    (cfg_pending),
    .pend_hi (pend_hi),
    .hi_act  (hi_act),
    .lo_act  (lo_act)
);

// File: tb/gate_pulse_gen_tb.sv
module gate_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W      = 26;
    localparam int GATE_W     = 16;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REF_W-1:0]  ref_hz = '0;
    logic [GATE_W-1:0] gate_ms = '0;
    logic              cfg_load = 1'b0;
    logic              gate_out;
    logic              edge_stb;
    logic              cfg_pending;

    int checks = 0;
    int fails  = 0;

    // scoreboard state
    int    q_hi[$];
    int    q_lo[$];
    string q_tag[$];
    int    cur_hi = 0, cur_lo = 0;
    string cur_tag = "";
    bit    have_cur = 0;
    int    adopted = 0;
    int    pushed = 0;
    int    periods_done = 0;
    int    tcyc = 0, t_rise = 0, t_fall = 0;
    bit    seen_fall = 0, prev_gate = 0, prev_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_pulse_gen #(.REF_W(REF_W), .GATE_W(GATE_W), .CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_hz      (ref_hz),
        .gate_ms     (gate_ms),
        .cfg_load    (cfg_load),
        .gate_out    (gate_out),
        .edge_stb    (edge_stb),
        .cfg_pending (cfg_pending)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // monitor: measures high/low runs at the ports, pops expected items on adoption
    always @(negedge clk) begin
        if (rst_n) begin
            if (gate_out != prev_gate || edge_stb)
                check(edge_stb == (gate_out != prev_gate), "R7", "edge strobe vs gate change",
                      int'(edge_stb), int'(gate_out != prev_gate));
            if (gate_out && !prev_gate) begin
                if (have_cur && seen_fall) begin
                    check((t_fall - t_rise) == cur_hi, cur_tag, "high run",
                          t_fall - t_rise, cur_hi);
                    check((tcyc - t_fall) == cur_lo, cur_tag, "low run",
                          tcyc - t_fall, cur_lo);
                    periods_done++;
                end
                if (prev_pend) begin
                    if (q_hi.size() == 0) begin
                        check(1'b0, "R6", "adoption with no queued settings", 1, 0);
                    end else begin
                        cur_hi  = q_hi.pop_front();
                        cur_lo  = q_lo.pop_front();
                        cur_tag = q_tag.pop_front();
                        have_cur = 1;
                        periods_done = 0;
                        adopted++;
                    end
                    check(cfg_pending == 1'b0, "R6", "pending cleared at adopting edge",
                          int'(cfg_pending), 0);
                end
                t_rise = tcyc;
                seen_fall = 0;
            end
            if (!gate_out && prev_gate) begin
                t_fall = tcyc;
                seen_fall = 1;
            end
            prev_gate = gate_out;
            prev_pend = cfg_pending;
            tcyc++;
        end
    end

    // driver: computes the expected runs from the requirements, then loads
    task automatic run_cfg(input int rhz, input int gms, input int n, input string tag);
        longint g, hi, tot;
        int my_id;
        bit got;
        g   = (gms < 50) ? 50 : ((gms > 60000) ? 60000 : gms);   // R4
        hi  = (longint'(rhz) * 40) / 1000;                        // R2
        tot = (longint'(rhz) * g + 500) / 1000;                   // R3
        q_hi.push_back(int'(hi));
        q_lo.push_back(int'(tot - hi));
        q_tag.push_back(tag);
        pushed++;
        my_id = pushed;
        @(negedge clk);
        ref_hz   = REF_W'(rhz);
        gate_ms  = GATE_W'(gms);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (cfg_pending) got = 1;
        end
        check(got, "R6", "pending raised after load", int'(got), 1);
        while (!(adopted == my_id && periods_done >= n)) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R6", "watchdog expired, cycles", WATCHDOG, WATCHDOG - 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(gate_out == 0 && edge_stb == 0 && cfg_pending == 0, "R1", "outputs in reset",
              int'({gate_out, edge_stb, cfg_pending}), 0);
        rst_n = 1'b1;
        begin
            bit quiet = 1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (gate_out || edge_stb || cfg_pending) quiet = 0;
            end
            check(quiet, "R1", "idle before first settings", int'(quiet), 1);
        end
        run_cfg(1000, 100, 3, "R5");      // first start: hi 40, lo 60
        run_cfg(1000, 250, 2, "R6");      // hi 40, lo 210; old periods checked until adoption
        run_cfg(1000, 10, 3, "R4");       // clamped to 50: hi 40, lo 10
        run_cfg(1010, 50, 3, "R3");       // 50.5 rounds up: hi 40, lo 11
        run_cfg(1001, 50, 2, "R3");       // 50.05 rounds down: hi 40, lo 10
        run_cfg(2500, 60, 2, "R2");       // hi 100, lo 50
        run_cfg(1000, 65000, 2, "R8");    // clamped to 60000, crosses counter wrap
        check(cfg_pending == 0, "R6", "no pending after last adoption", int'(cfg_pending), 0);
        summary();
        $finish;
    end
endmodule